// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit data input of a single-wire bus transceiver and the control of its low-side bus driver. A low level on the transmit input asks for the dominant bus state and a high level asks for recessive. The guard passes that request to the driver. If the input stays dominant for too long, which can happen when a controller hangs or a pin is shorted, the guard turns the driver off and latches a timeout. A single rising edge does not clear the latch. The transmit input has to stay high without a break for a minimum number of cycles before the driver may go dominant again.

The same block returns the sampled bus level on the receive output. Both pin inputs pass through reset-to-recessive synchronizers, so an unconnected, pulled-up input behaves as recessive. The guard acts only while `enable` is high, which means the transceiver is in normal operating mode. With `enable` low, the driver stays recessive and all timing state is discarded. At 125 MHz the default limits stand for about 27 ms of dominant time and a little over 10 µs of recovery time.

Top module: `tx_dom_guard`

## Requirements
- R1: During and after reset, `drv_dominant` is 0, `timeout_flag` is 0 and `rx_out` is 1 (recessive). The synchronizers reset to the recessive level.
- R2: While enabled and not timed out, `tx_in` = 0 sets `drv_dominant` = 1 exactly SYNC_STAGES+1 clock edges later. A low run of n < DOM_LIMIT cycles gives exactly n cycles of `drv_dominant` = 1.
- R3: A low run on the synchronized transmit input that reaches DOM_LIMIT consecutive cycles sets `timeout_flag` = 1 and drives `drv_dominant` to 0 on the same edge. The driver therefore never stays dominant for more than DOM_LIMIT-1 cycles in one run.
- R4: Once set, `timeout_flag` stays 1 until the synchronized transmit input has been 1 for REARM_LIMIT consecutive cycles. The flag clears on the edge that completes that run. For one low run of n ≥ DOM_LIMIT cycles followed by a long high level, the flag is high for n-DOM_LIMIT+REARM_LIMIT cycles.
- R5: A high level shorter than REARM_LIMIT cycles during a timeout restarts the recovery count. The flag stays set, and a following low level does not make the driver dominant.
- R6: While `enable` = 0, `drv_dominant` is 0 on the next edge, `timeout_flag` clears on the next edge, and both counters are cleared. When `enable` returns with `tx_in` low, the driver goes dominant again on the next edge.
- R7: `rx_out` follows `bus_in` (1 = recessive, 0 = dominant) with a latency of SYNC_STAGES edges, independent of `enable`.
- R8: `drv_dominant` is never 1 while `timeout_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | 1 = normal mode, guard active |
| tx_in | input | 1 | Transmit level from the controller, 0 = dominant |
| bus_in | input | 1 | Sampled bus level, 0 = dominant |
| drv_dominant | output | 1 | 1 = turn the bus driver on (dominant) |
| rx_out | output | 1 | Receive level to the controller, 0 = dominant |
| timeout_flag | output | 1 | 1 while the dominant timeout is latched |

## Verification
A transmit level applied before edge k appears at the guard logic after SYNC_STAGES edges. The driver output and the flag are registered one edge later, and the receive output has the synchronizer latency alone. The bench drives and samples only at falling edges, so every result is read half a cycle after the edge that produced it. Most checks count the cycles of driver and flag activity over a full stimulus and compare them with closed-form counts derived from the run lengths. The receive and enable checks sample at the exact edge offset stated in the requirement, and one edge before it where that matters.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic {
        LVL_DOM = 1'b0,
        LVL_REC = 1'b1
    } bus_lvl_e;

    typedef struct packed {
        logic locked;
        logic drv;
    } guard_state_t;

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb st_d = d_in;
        end else begin : g_chain
            always_comb st_d = {st_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q_out = st_q[STAGES-1];
endmodule

// File: rtl/guard_dom_timer.sv
module guard_dom_timer #(
    parameter int LIMIT = 3375000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)              cnt_d = '0;
        else if (cnt_q < TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = !clr && (cnt_q == LAST);

    // R3: the dominant run counter saturates and never passes its limit
    a_r3_dom_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    // R6: a clear request empties the counter on the next edge
    a_r6_dom_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/guard_rearm_timer.sv
module guard_rearm_timer #(
    parameter int LIMIT = 1251
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);

    // R4: the recovery counter stays below its limit
    a_r4_rearm_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R5: a break in the high run restarts recovery from zero
    a_r5_rearm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
    parameter int SYNC_STAGES = 2,
    parameter int DOM_LIMIT   = 3375000,
    parameter int REARM_LIMIT = 1251
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_in,
    input  logic bus_in,
    output logic drv_dominant,
    output logic rx_out,
    output logic timeout_flag
);
    import guard_pkg::*;

    logic         tx_s;
    logic         bus_s;
    logic         dom_clr;
    logic         dom_expire;
    logic         rearm_run;
    logic         rearm_done;
    guard_state_t st_d, st_q;

    guard_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LVL_REC)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .d_in(tx_in), .q_out(tx_s)
    );

    guard_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LVL_REC)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d_in(bus_in), .q_out(bus_s)
    );

    assign dom_clr   = !enable || (tx_s == LVL_REC);
    assign rearm_run = enable && st_q.locked && (tx_s == LVL_REC);

    guard_dom_timer #(.LIMIT(DOM_LIMIT)) u_dom_timer (
        .clk(clk), .rst_n(rst_n), .clr(dom_clr), .expire(dom_expire)
    );

    guard_rearm_timer #(.LIMIT(REARM_LIMIT)) u_rearm_timer (
        .clk(clk), .rst_n(rst_n), .run(rearm_run), .done(rearm_done)
    );

    always_comb begin
        st_d = st_q;
        if (!enable)          st_d.locked = 1'b0;
        else if (st_q.locked) st_d.locked = !rearm_done;
        else                  st_d.locked = dom_expire;
        st_d.drv = enable && (tx_s == LVL_DOM) && !st_d.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv_dominant = st_q.drv;
    assign timeout_flag = st_q.locked;
    assign rx_out       = bus_s;

    // R8: driver off whenever the timeout is latched
    a_r8_no_drive_locked: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> !drv_dominant);
    // R2: the driver only goes dominant after a dominant request while enabled
    a_r2_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dominant |-> ($past(tx_s) == LVL_DOM) && $past(enable));
    // R3: the latch only sets during a dominant request
    a_r3_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(tx_s) == LVL_DOM);
    // R4: with the guard enabled, release needs a recessive input
    a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(timeout_flag) && $past(enable)) |-> $past(tx_s) == LVL_REC);
    // R6: disabling forces the driver recessive and drops the latch
    a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !drv_dominant && !timeout_flag);
endmodule

// File: tb/tx_dom_guard_tb_top.sv
module tx_dom_guard_tb_top;
    localparam int L  = 2;
    localparam int DL = 8;
    localparam int RL = 4;
    localparam int W  = RL + L + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic tx_in = 1'b1;
    logic bus_in = 1'b1;
    logic drv_dominant, rx_out, timeout_flag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int dcnt = 0;
    int fcnt = 0;

    always #4 clk = ~clk;

    tx_dom_guard #(.SYNC_STAGES(L), .DOM_LIMIT(DL), .REARM_LIMIT(RL)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_in(tx_in),
        .bus_in(bus_in), .drv_dominant(drv_dominant), .rx_out(rx_out),
        .timeout_flag(timeout_flag)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 60000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp=<60000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // each cycle: sample at the falling edge, then drive the new level
    task automatic seg(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dcnt = dcnt + int'(drv_dominant);
            fcnt = fcnt + int'(timeout_flag);
            tx_in = lvl;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(drv_dominant == 1'b0, "R1 drv in reset", int'(drv_dominant), 0);
        chk(timeout_flag == 1'b0, "R1 flag in reset", int'(timeout_flag), 0);
        chk(rx_out == 1'b1, "R1 rx in reset", int'(rx_out), 1);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(drv_dominant == 1'b0 && timeout_flag == 1'b0, "R1 idle after reset",
            int'(drv_dominant), 0);

        // R2: latency of the driver response
        tx_in = 1'b0;
        repeat (L) @(negedge clk);
        chk(drv_dominant == 1'b0, "R2 drv one edge early", int'(drv_dominant), 0);
        @(negedge clk);
        chk(drv_dominant == 1'b1, "R2 drv at latency", int'(drv_dominant), 1);
        tx_in = 1'b1;
        repeat (W) @(negedge clk);

        // R2/R3/R4: sweep of low run lengths
        for (int n = 1; n <= DL + 4; n++) begin
            dcnt = 0; fcnt = 0;
            seg(1'b0, n);
            seg(1'b1, W);
            if (n < DL) begin
                chk(dcnt == n, "R2 drive cycles", dcnt, n);
                chk(fcnt == 0, "R2 no timeout", fcnt, 0);
            end else begin
                chk(dcnt == DL - 1, "R3 drive capped", dcnt, DL - 1);
                chk(fcnt == n - DL + RL, "R4 flag duration", fcnt, n - DL + RL);
            end
        end

        // R5: short recessive gaps restart recovery
        for (int h = 1; h < RL; h++) begin
            dcnt = 0; fcnt = 0;
            seg(1'b0, DL + 1);
            seg(1'b1, h);
            seg(1'b0, 2);
            seg(1'b1, W);
            chk(dcnt == DL - 1, "R5 no drive after gap", dcnt, DL - 1);
            chk(fcnt == 2 + h + 2 + RL - 1, "R5 flag held", fcnt, 2 + h + 2 + RL - 1);
        end

        // R6: disabled guard never drives
        enable = 1'b0;
        dcnt = 0; fcnt = 0;
        seg(1'b0, DL + 3);
        seg(1'b1, W);
        chk(dcnt == 0, "R6 disabled drive", dcnt, 0);
        chk(fcnt == 0, "R6 disabled flag", fcnt, 0);
        enable = 1'b1;

        // R6: disabling clears a latched timeout
        dcnt = 0; fcnt = 0;
        seg(1'b0, DL + L + 3);
        chk(timeout_flag == 1'b1, "R3 latched", int'(timeout_flag), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(timeout_flag == 1'b0, "R6 flag cleared", int'(timeout_flag), 0);
        chk(drv_dominant == 1'b0, "R6 drv off", int'(drv_dominant), 0);
        enable = 1'b1;
        @(negedge clk);
        chk(drv_dominant == 1'b1, "R6 drive resumes", int'(drv_dominant), 1);
        seg(1'b1, W);

        // R7: receive path latency, both levels, both enable states
        for (int e = 0; e < 2; e++) begin
            enable = e[0];
            for (int v = 0; v < 2; v++) begin
                logic old;
                old = rx_out;
                bus_in = v[0];
                repeat (L - 1) @(negedge clk);
                chk(rx_out == old, "R7 rx before latency", int'(rx_out), int'(old));
                @(negedge clk);
                chk(rx_out == v[0], "R7 rx at latency", int'(rx_out), v);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule